// File: doc/BRIEF.md
# Tri-State Phase Detector with Lock Indication

This block compares two single-cycle tick streams for one synthesizer loop. One is the divided reference and the other is the divided feedback from the oscillator. It reports the phase error on a three-state output. That output is modelled as a drive enable plus a drive level, and it feeds a charge pump or a loop filter further downstream. When the feedback tick comes late, the output drives high. When the feedback tick comes early, the output drives low. When the two ticks coincide, the output stays undriven, which is the high-impedance state. The length of each drive pulse, in system clocks, equals the distance between the two ticks.

Two internal flags hold the pending error, one for "reference seen first" and one for "feedback seen first". A second tick on the same side before the opposite tick arrives keeps the flag set, so a frequency error produces a persistent drive in one direction. A lock indicator goes high while one error pulse has lasted beyond a short glitch window. A power-down input stops the detector and releases the output.

Top module: `pfd_lock`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, pd_drive_o and out_of_lock_o are 0.
- R2: A reference tick with no feedback tick, arriving while the output is idle, makes the block drive high (pd_drive_o=1, pd_level_o=1) from the next cycle.
- R3: A feedback tick with no reference tick, arriving while the output is idle, makes the block drive low (pd_drive_o=1, pd_level_o=0) from the next cycle.
- R4: While the block is driving, a tick on the opposite side ends the drive in the next cycle. A pulse whose ticks are N cycles apart therefore lasts exactly N cycles.
- R5: Reference and feedback ticks in the same cycle, arriving while the output is idle, cause no drive. The output stays high-impedance (pd_drive_o=0).
- R6: Further ticks on the same side as the pending flag do not change the drive. The drive holds its level until the opposite tick arrives.
- R7: out_of_lock_o is 1 exactly in the cycles from the (GLITCH_CYC+1)-th cycle of one continuous drive pulse onward, to the end of that pulse (default GLITCH_CYC=2, so from the third cycle). It is 0 in all other cycles.
- R8: While pwr_down_i is 1, pd_drive_o and out_of_lock_o are 0 in the same cycle. Ticks are ignored, and after release the output stays idle until a new tick arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down_i | input | 1 | Power-down; forces the output to high impedance |
| ref_tick_i | input | 1 | Single-cycle divided reference tick |
| fb_tick_i | input | 1 | Single-cycle divided feedback tick |
| pd_drive_o | output | 1 | 1 = output driven, 0 = high impedance |
| pd_level_o | output | 1 | Driven level when pd_drive_o is 1 (1 high, 0 low) |
| out_of_lock_o | output | 1 | 1 while the loop is out of lock |

## Verification
The hardest situation to reach from the ports is a pulse that has already tripped the lock indicator and is then ended by an opposite tick. That tick arrives in the same cycle as a repeated same-side tick, or during a power-down edge. The stimulus first builds long pulses by sending several reference ticks before the feedback tick. It then runs a pseudo-random phase section in which both tick streams fire with independent probabilities and power-down toggles occasionally, so coincident and overlapping edges occur many times. A behavioural queue-free model in the bench is compared against all three outputs on every clock.

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int GLITCH_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down_i,
  input  logic ref_tick_i,
  input  logic fb_tick_i,
  output logic pd_drive_o,
  output logic pd_level_o,
  output logic out_of_lock_o
);

  localparam int RUN_W = $clog2(GLITCH_CYC + 1) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GLITCH_CYC);

  logic             up_q, dn_q;
  logic [RUN_W-1:0] run_q;

  logic up_set, dn_set, both_set;
  logic up_nxt, dn_nxt, err_now, err_nxt;
  logic [RUN_W-1:0] run_nxt;

  assign up_set   = up_q | ref_tick_i;
  assign dn_set   = dn_q | fb_tick_i;
  assign both_set = up_set & dn_set;
  assign up_nxt   = up_set & ~both_set;
  assign dn_nxt   = dn_set & ~both_set;
  assign err_now  = up_q | dn_q;
  assign err_nxt  = up_nxt | dn_nxt;

  always_comb begin
    if (err_nxt && err_now)
      run_nxt = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
    else
      run_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down_i) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      run_q <= '0;
    end else begin
      up_q  <= up_nxt;
      dn_q  <= dn_nxt;
      run_q <= run_nxt;
    end
  end

  assign pd_drive_o    = (up_q ^ dn_q) & ~pwr_down_i;
  assign pd_level_o    = up_q;
  assign out_of_lock_o = err_now & (run_q == RUN_MAX) & ~pwr_down_i;

endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_down_i,
  input logic ref_tick_i,
  input logic fb_tick_i,
  input logic pd_drive_o,
  input logic pd_level_o,
  input logic out_of_lock_o
);

  assert_ref_drives_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down_i && ref_tick_i && !fb_tick_i && !pd_drive_o) |=> (pwr_down_i || (pd_drive_o && pd_level_o)));

  assert_fb_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down_i && fb_tick_i && !ref_tick_i && !pd_drive_o) |=> (pwr_down_i || (pd_drive_o && !pd_level_o)));

  assert_opposite_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down_i && pd_drive_o && !pd_level_o && ref_tick_i) |=> !pd_drive_o);

  assert_coincident_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_drive_o && ref_tick_i && fb_tick_i) |=> !pd_drive_o);

  assert_lock_needs_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_lock_o |-> pd_drive_o);

  assert_lock_after_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_of_lock_o) |-> ($past(pd_drive_o) && $past(pd_drive_o, 2)));

  assert_powerdown_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |-> (!pd_drive_o && !out_of_lock_o));

endmodule

bind pfd_lock pfd_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down_i(pwr_down_i),
  .ref_tick_i(ref_tick_i), .fb_tick_i(fb_tick_i),
  .pd_drive_o(pd_drive_o), .pd_level_o(pd_level_o), .out_of_lock_o(out_of_lock_o)
);

// File: tb/pfd_lock_tb.sv
module pfd_lock_tb;
  localparam int GLITCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down_i = 1'b0;
  logic ref_tick_i = 1'b0;
  logic fb_tick_i = 1'b0;
  logic pd_drive_o, pd_level_o, out_of_lock_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  pfd_lock #(.GLITCH_CYC(GLITCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down_i(pwr_down_i),
    .ref_tick_i(ref_tick_i), .fb_tick_i(fb_tick_i),
    .pd_drive_o(pd_drive_o), .pd_level_o(pd_level_o), .out_of_lock_o(out_of_lock_o)
  );

  // behavioural model: pending side (+1 ref first, -1 fb first, 0 none) and pulse age
  int m_side = 0;
  int m_age = 0;

  always @(posedge clk) begin
    if (!rst_n || pwr_down_i) begin
      m_side = 0;
      m_age = 0;
    end else if (m_side == 0) begin
      if (ref_tick_i && !fb_tick_i) m_side = 1;
      else if (fb_tick_i && !ref_tick_i) m_side = -1;
      m_age = 0;
    end else if ((m_side == 1 && fb_tick_i) || (m_side == -1 && ref_tick_i)) begin
      m_side = 0;
      m_age = 0;
    end else begin
      m_age = m_age + 1;
    end
  end

  task automatic cmp_model();
    bit e_drv, e_lvl, e_lock;
    e_drv  = (m_side != 0) && !pwr_down_i;
    e_lvl  = (m_side == 1);
    e_lock = e_drv && (m_age >= GLITCH);
    checks++;
    if (pd_drive_o !== e_drv || (e_drv && pd_level_o !== e_lvl) || out_of_lock_o !== e_lock) begin
      fails++;
      $display("FAIL %s model: drive/level/lock=%b%b%b expected %b%b%b at %0t",
               cur_req, pd_drive_o, pd_level_o, out_of_lock_o, e_drv, e_lvl, e_lock, $time);
    end
  endtask

  task automatic cyc(input bit r, input bit f, input bit p);
    ref_tick_i = r;
    fb_tick_i = f;
    pwr_down_i = p;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic expect_out(input string req, input bit drv, input bit lvl, input bit lock);
    checks++;
    if (pd_drive_o !== drv || (drv && pd_level_o !== lvl) || out_of_lock_o !== lock) begin
      fails++;
      $display("FAIL %s directed: drive/level/lock=%b%b%b expected %b%b%b at %0t",
               req, pd_drive_o, pd_level_o, out_of_lock_o, drv, lvl, lock, $time);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    @(negedge clk);
    cur_req = "R1";
    ref_tick_i = 1'b1;
    @(negedge clk);
    expect_out("R1", 0, 0, 0);
    ref_tick_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0); expect_out("R1", 0, 0, 0);

    // R2 + R4 + R7: ref leads by 3 cycles
    cur_req = "R2";
    cyc(1, 0, 0); expect_out("R2", 1, 1, 0);
    cur_req = "R7";
    cyc(0, 0, 0); expect_out("R7", 1, 1, 0);
    cyc(0, 0, 0); expect_out("R7", 1, 1, 1);
    cur_req = "R4";
    cyc(0, 1, 0); expect_out("R4", 0, 0, 0);
    cyc(0, 0, 0);

    // R3 + R4: fb leads by one cycle, no lock alarm
    cur_req = "R3";
    cyc(0, 1, 0); expect_out("R3", 1, 0, 0);
    cur_req = "R4";
    cyc(1, 0, 0); expect_out("R4", 0, 0, 0);

    // R5: coincident ticks
    cur_req = "R5";
    cyc(1, 1, 0); expect_out("R5", 0, 0, 0);
    cyc(0, 0, 0); expect_out("R5", 0, 0, 0);

    // R6: repeated reference ticks keep the high drive
    cur_req = "R6";
    cyc(1, 0, 0); expect_out("R6", 1, 1, 0);
    cyc(1, 0, 0); expect_out("R6", 1, 1, 0);
    cyc(1, 0, 0); expect_out("R6", 1, 1, 1);
    cyc(1, 1, 0); expect_out("R6", 0, 0, 0);

    // R6: repeated feedback ticks, then ref and fb together end the low drive
    cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0); expect_out("R6", 1, 0, 1);
    cur_req = "R4";
    cyc(1, 1, 0); expect_out("R4", 0, 0, 0);

    // R8: power-down during a pulse, ticks ignored, idle after release
    cur_req = "R8";
    cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0); expect_out("R8", 1, 1, 1);
    pwr_down_i = 1'b1;
    #1 expect_out("R8", 0, 0, 0);
    cyc(1, 0, 1); expect_out("R8", 0, 0, 0);
    cyc(0, 1, 1); expect_out("R8", 0, 0, 0);
    cyc(0, 0, 0); expect_out("R8", 0, 0, 0);
    cyc(0, 0, 0); expect_out("R8", 0, 0, 0);

    // pseudo-random phase section
    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      bit r, f, p;
      seed = seed * 1103515245 + 12345;
      r = ((seed >>> 16) & 7) == 0;
      f = ((seed >>> 20) & 7) == 1;
      p = ((seed >>> 24) & 63) == 5;
      cyc(r, f, p);
    end

    cur_req = "R1";
    rst_n = 1'b0;
    cyc(1, 0, 0); expect_out("R1", 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule